// File: doc/BRIEF.md
# Disparity-Parallel Path-Cost Aggregation Element

This block is one aggregation element for semi-global stereo matching. It follows a single path direction through a stream of pixels and, for each pixel, turns the per-disparity matching costs into path costs. The costs come from the previous pixel on the path and from the two smoothness penalties. Each transfer carries a group of `DM` neighbouring disparity levels. The groups of a pixel arrive in ascending order, so a pixel with full stereo overlap takes `D/DM` transfers. The previous pixel's path costs sit in a local store of `D/DM` entries, each `DM` cost words wide. Its total size does not depend on `DM`.

Near the left image border, the disparities that exceed the pixel's column have no stereo overlap. Groups made up only of such disparities are never transferred, and the lanes that exceed the column in a partly covered group produce the infinite cost. Path costs leave the block in the order in which their matching costs arrived. A downstream first-in first-out memory can therefore keep the last row of one slice and replay it, unchanged, as the seed row of the next slice.

Top module: `sgm_path_pe`

## Requirements
- R1: Transfer `k` of a pixel carries disparities `k*DM + j` in lane `j`, where lane `j` occupies bits `[j*W +: W]` of `in_cost` and of `out_cost`. A pixel whose column is at least `D-1` takes exactly `D/DM` transfers.
- R2: A transfer happens in a cycle where `in_valid` and `out_ready` are both high. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle, and `out_cost` belongs to the group currently presented. While `out_ready` is low, no internal state changes.
- R3: When `in_sor` is high on the first transfer of a pixel, the pixel starts a new path. Each of its covered lanes outputs its matching cost unchanged.
- R4: For any other pixel, covered lane `d` outputs `C(d) + min(Lp(d), Lp(d-1)+P1, Lp(d+1)+P1, Mp+P2) - Mp`. Here `Lp` is the previous pixel's path cost, `Mp` is its minimum, and `P1`/`P2` are the `p1`/`p2` inputs.
- R5: The neighbours `d-1` and `d+1` are taken from the previous pixel, including across group boundaries. A disparity below 0 or above `D-1` counts as infinite cost.
- R6: `Mp` is the minimum of the previous pixel's path costs over its covered disparities. It changes only on the last transfer of a pixel.
- R7: Every path cost saturates at `2^W-1`, and a covered lane never exceeds `min(2^W-1, C(d)+P2)`.
- R8: A pixel with column `x < D-1` takes `floor(x/DM)+1` transfers. Lanes with `d > x` output `2^W-1`. Disparities above the previous pixel's column count as infinite cost.
- R9: After reset the group position is 0, `out_valid` is low while `in_valid` is low, and the stored previous costs are infinite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p1 | input | W | Penalty for a one-level disparity change |
| p2 | input | W | Penalty for a larger disparity change |
| in_valid | input | 1 | A group of matching costs is presented |
| in_ready | output | 1 | The group is accepted this cycle |
| in_sor | input | 1 | First pixel of a path (read on the pixel's first transfer) |
| in_col | input | XW | Column of the current pixel |
| in_cost | input | DM*W | Matching costs of the group, lane j at bits j*W |
| out_valid | output | 1 | A group of path costs is presented |
| out_ready | input | 1 | Downstream accepts the path costs |
| out_cost | output | DM*W | Path costs of the group, lane j at bits j*W |

## Verification
The assertions assume a well-formed input stream. `in_col`, `in_sor` and `p1`/`p2` stay constant across all transfers of one pixel, the producer sends exactly the number of groups that the column allows, and the first pixel after reset carries `in_sor`. The bench presents every pixel as a whole burst with these values held, and it changes the penalties only between pixels. Stalls are produced only by lowering `out_ready`, with the presented group held steady.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  function automatic int umin(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/sgm_grp_min.sv
module sgm_grp_min #(
  parameter int W = 10,
  parameter int N = 2
) (
  input  logic [N*W-1:0] vals,
  input  logic [N-1:0]   mask,
  output logic [W-1:0]   min_o
);
  always_comb begin
    min_o = '1;
    for (int j = 0; j < N; j++) begin
      if (mask[j] && vals[j*W +: W] < min_o) min_o = vals[j*W +: W];
    end
  end
endmodule

// File: rtl/sgm_lane.sv
module sgm_lane #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chk_en,
  input  logic         first,
  input  logic         active,
  input  logic [W-1:0] cost,
  input  logic [W-1:0] lp_self,
  input  logic [W-1:0] lp_lo,
  input  logic [W-1:0] lp_hi,
  input  logic [W-1:0] min_prev,
  input  logic [W-1:0] p1,
  input  logic [W-1:0] p2,
  output logic [W-1:0] l_out
);
  localparam int EW = W + 2;
  localparam logic [EW-1:0] SATV = EW'((1 << W) - 1);

  logic [EW-1:0] c_self, c_lo, c_hi, c_jump, best, raw;

  always_comb begin
    c_self = EW'(lp_self);
    c_lo   = EW'(lp_lo) + EW'(p1);
    c_hi   = EW'(lp_hi) + EW'(p1);
    c_jump = EW'(min_prev) + EW'(p2);
    best   = c_self;
    if (c_lo < best)   best = c_lo;
    if (c_hi < best)   best = c_hi;
    if (c_jump < best) best = c_jump;
    raw = first ? EW'(cost) : (EW'(cost) + best - EW'(min_prev));
    if (!active)        l_out = '1;
    else if (raw > SATV) l_out = '1;
    else                l_out = raw[W-1:0];
  end

  // R3
  first_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && first && active |-> l_out == cost);

  // R7
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && active |-> (EW'(l_out) <= EW'(cost) + EW'(p2)) || (l_out == '1));

  // R8
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && !active |-> l_out == '1);
endmodule

// File: rtl/sgm_path_pe.sv
module sgm_path_pe #(
  parameter int D  = 8,
  parameter int DM = 2,
  parameter int W  = 10,
  parameter int XW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   p1,
  input  logic [W-1:0]   p2,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_sor,
  input  logic [XW-1:0]  in_col,
  input  logic [DM*W-1:0] in_cost,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DM*W-1:0] out_cost
);
  import sgm_pkg::*;

  localparam int NG = D / DM;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;
  localparam logic [W-1:0] MAXC = '1;

  logic [DM*W-1:0] buf_q [NG];
  logic [GW-1:0]   grp_q, nxt;
  logic            first_q, is_first, fire, last;
  logic [XW-1:0]   prev_col_q;
  logic [W-1:0]    min_prev_q, run_min_q, lo_edge_q, gmin, run_next;
  logic [W-1:0]    ext [DM+2];
  logic [DM-1:0]   act;

  assign fire      = in_valid && out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign is_first  = (grp_q == '0) ? in_sor : first_q;
  assign nxt       = grp_q + GW'(1);

  always_comb begin
    int lim;
    lim  = umin(int'(in_col), D - 1);
    last = (int'(grp_q) == lim / DM);
    ext[0] = (grp_q == '0) ? MAXC : lo_edge_q;
    for (int j = 0; j < DM; j++) begin
      int d;
      d = int'(grp_q) * DM + j;
      ext[j+1] = (d <= int'(prev_col_q)) ? buf_q[grp_q][j*W +: W] : MAXC;
      act[j]   = (d <= int'(in_col));
    end
    if (int'(grp_q) == NG - 1 || (int'(grp_q) * DM + DM) > int'(prev_col_q))
      ext[DM+1] = MAXC;
    else
      ext[DM+1] = buf_q[nxt][W-1:0];
  end

  for (genvar j = 0; j < DM; j++) begin : g_lane
    sgm_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .chk_en(fire),
      .first(is_first), .active(act[j]),
      .cost(in_cost[j*W +: W]),
      .lp_self(ext[j+1]), .lp_lo(ext[j]), .lp_hi(ext[j+2]),
      .min_prev(min_prev_q), .p1(p1), .p2(p2),
      .l_out(out_cost[j*W +: W])
    );
  end

  sgm_grp_min #(.W(W), .N(DM)) u_min (
    .vals(out_cost), .mask(act), .min_o(gmin)
  );

  assign run_next = (gmin < run_min_q) ? gmin : run_min_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q      <= '0;
      first_q    <= 1'b0;
      prev_col_q <= '0;
      min_prev_q <= MAXC;
      run_min_q  <= MAXC;
      lo_edge_q  <= MAXC;
      for (int g = 0; g < NG; g++) buf_q[g] <= '1;
    end else if (fire) begin
      buf_q[grp_q] <= out_cost;
      lo_edge_q    <= ext[DM];
      if (grp_q == '0) first_q <= in_sor;
      if (last) begin
        grp_q      <= '0;
        min_prev_q <= run_next;
        run_min_q  <= MAXC;
        prev_col_q <= in_col;
      end else begin
        grp_q     <= nxt;
        run_min_q <= run_next;
      end
    end
  end

  // R8
  pixel_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last |=> grp_q == '0);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(grp_q) && $stable(min_prev_q) && $stable(prev_col_q));

  // R6
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> $stable(min_prev_q));

  // R1
  group_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> grp_q != '0);
endmodule

// File: tb/sgm_path_pe_tb.sv
module sgm_path_pe_tb;
  localparam int D = 8, DM = 2, W = 10, XW = 10;
  localparam int INF = (1 << W) - 1;
  localparam int NV = 14;
  // vector: {sor, col[9:0], seed[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 10'd0, 8'd3},  {1'b0, 10'd1, 8'd9},  {1'b0, 10'd2, 8'd14},
    {1'b0, 10'd3, 8'd21}, {1'b0, 10'd4, 8'd5},  {1'b0, 10'd7, 8'd40},
    {1'b0, 10'd8, 8'd77}, {1'b0, 10'd9, 8'd11}, {1'b0, 10'd10, 8'd60},
    {1'b1, 10'd0, 8'd88}, {1'b0, 10'd1, 8'd2},  {1'b0, 10'd2, 8'd99},
    {1'b0, 10'd5, 8'd31}, {1'b0, 10'd6, 8'd17}};

  logic clk = 0, rst_n = 0;
  logic [W-1:0] p1 = 10'd3, p2 = 10'd20;
  logic in_valid = 0, in_sor = 0, out_ready = 1;
  logic [XW-1:0] in_col = '0;
  logic [DM*W-1:0] in_cost = '0;
  logic in_ready, out_valid;
  logic [DM*W-1:0] out_cost;

  int checks = 0, fails = 0;
  int cin [D];
  int lp [D];
  int pcol, minp;

  always #10 clk = ~clk;

  sgm_path_pe #(.D(D), .DM(DM), .W(W), .XW(XW)) u_dut (
    .clk(clk), .rst_n(rst_n), .p1(p1), .p2(p2),
    .in_valid(in_valid), .in_ready(in_ready), .in_sor(in_sor),
    .in_col(in_col), .in_cost(in_cost),
    .out_valid(out_valid), .out_ready(out_ready), .out_cost(out_cost));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pv(int x);
    if (x < 0 || x >= D || x > pcol) return INF;
    return lp[x];
  endfunction

  task automatic send_pixel(bit sor, int col, bit stall);
    int e [D];
    int lim, ng, m;
    for (int d = 0; d < D; d++) begin
      if (d > col) e[d] = INF;
      else if (sor) e[d] = cin[d];
      else begin
        int b;
        b = pv(d);
        if (pv(d-1) + int'(p1) < b) b = pv(d-1) + int'(p1);
        if (pv(d+1) + int'(p1) < b) b = pv(d+1) + int'(p1);
        if (minp + int'(p2) < b) b = minp + int'(p2);
        e[d] = cin[d] + b - minp;
        if (e[d] > INF) e[d] = INF;
      end
    end
    lim = (col < D-1) ? col : D-1;
    ng = lim / DM + 1;
    for (int g = 0; g < ng; g++) begin
      @(negedge clk);
      in_valid = 1; in_sor = sor; in_col = XW'(col);
      for (int j = 0; j < DM; j++) in_cost[j*W +: W] = W'(cin[g*DM+j]);
      if (stall && g == 0) begin
        out_ready = 0;
        #2;
        check("R2 in_ready low under back-pressure", int'(in_ready), 0);
        repeat (3) @(negedge clk);
        out_ready = 1;
      end
      #2;
      check("R2 out_valid follows in_valid", int'(out_valid), 1);
      for (int j = 0; j < DM; j++)
        check(sor ? "R3/R1 lane cost" : "R4/R5/R8 lane cost",
              int'(out_cost[j*W +: W]), e[g*DM+j]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0;
    m = INF;
    for (int d = 0; d < D; d++) begin
      lp[d] = e[d];
      if (d <= col && e[d] < m) m = e[d];
    end
    minp = m; pcol = col;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < D; d++) lp[d] = INF;
    pcol = 0; minp = INF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 out_valid low with no input", int'(out_valid), 0);
    check("R9 in_ready follows out_ready", int'(in_ready), 1);
    rst_n = 1;

    // table walk: R1, R3, R4, R5, R6, R8
    for (int v = 0; v < NV; v++) begin
      int seed;
      seed = int'(VEC[v][7:0]);
      for (int d = 0; d < D; d++) cin[d] = (seed * 7 + d * 13 + d * d * 3) % 97;
      send_pixel(VEC[v][18], int'(VEC[v][17:8]), 1'b0);
    end

    // R2: back-pressure leaves state untouched
    for (int d = 0; d < D; d++) cin[d] = (d * 29 + 5) % 61;
    send_pixel(1'b0, 11, 1'b1);

    // R4: new penalties between pixels
    p1 = 10'd9; p2 = 10'd40;
    for (int d = 0; d < D; d++) cin[d] = (d * 41 + 7) % 83;
    send_pixel(1'b0, 12, 1'b0);

    // R7: saturation at the cost ceiling
    p1 = 10'd3; p2 = 10'd20;
    for (int d = 0; d < D; d++) cin[d] = (d % 2 == 0) ? INF : 0;
    send_pixel(1'b1, 20, 1'b0);
    for (int d = 0; d < D; d++) cin[d] = 1022;
    send_pixel(1'b0, 21, 1'b0);

    // R8: border pixel inside a new row
    for (int d = 0; d < D; d++) cin[d] = 50 + d;
    send_pixel(1'b1, 0, 1'b0);
    for (int d = 0; d < D; d++) cin[d] = 10 + 3 * d;
    send_pixel(1'b0, 1, 1'b0);

    // R9: reset clears stored state; a following start pixel passes costs
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R9 out_valid low in reset", int'(out_valid), 0);
    rst_n = 1;
    for (int d = 0; d < D; d++) lp[d] = INF;
    pcol = 0; minp = INF;
    for (int d = 0; d < D; d++) cin[d] = 100 + d;
    send_pixel(1'b1, 9, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule